// File: doc/BRIEF.md
# Transactional Footprint and Conflict Tracker

This block follows the memory footprint of one hardware thread while it runs a speculative transaction. Every load the thread issues inside the transaction marks the cache line it touched in a small read table. Every store marks its line in a write table, and the store data is kept in a private buffer instead of going to memory. Addresses snooped from other agents are compared against both tables. A conflicting snoop ends the transaction with an abort. A store that needs a fresh slot in a full table also ends it with an abort. On a successful end, the buffered lines leave for memory one per cycle as a single atomic group. On an abort, the buffer and both tables are simply emptied.

A write that takes a lock at the start of a lock-elided region is reported on the access port with its own kind code. The block records that write in the read table, not the write table. Many threads can then elide the same lock without colliding on the lock word, and the lock word is never drained to memory.

The control is a three-state machine: IDLE, ACTIVE and DRAIN. The transitions are:

- BEGIN: IDLE to ACTIVE, on `tx_begin`.
- CONFLICT-ABORT: ACTIVE to IDLE, on a conflicting snoop.
- EMPTY-COMMIT: ACTIVE to IDLE, on `tx_end` with no buffered lines.
- COMMIT: ACTIVE to DRAIN, on `tx_end` with at least one buffered line.
- CAPACITY-ABORT: ACTIVE to IDLE, on a table overflow.
- DRAIN-DONE: DRAIN to IDLE, after the last buffered line has been presented.

Top module: `txn_footprint_tracker`

## Requirements
- R1: Tracking is per cache line. The line is `addr[ADDR_W-1:OFF_W]`, and the low `OFF_W` offset bits are ignored. Repeated accesses to one line occupy a single entry.
- R2: Accesses are recorded only in ACTIVE. The kind code on `acc_kind` is 00 for a load (read table), 01 for a store (write table) and 10 for a lock-taking write. Accesses in IDLE are neither recorded nor buffered.
- R3: Buffered store data never appears on the memory write port while the transaction is ACTIVE.
- R4: A remote write (`snp_is_write`=1) to a line held in either table produces `abort_pulse` one cycle later with `abort_code` 01.
- R5: A remote read to a line in the write table aborts with code 01. A remote read to a line only in the read table has no effect.
- R6: A lock-taking write (kind 10) is recorded in the read table only. It uses no write-table slot and is never drained at commit.
- R7: The read table holds `RD_DEPTH` (8) lines and the write table holds `WR_DEPTH` (4) lines. An access that needs a new line while its table is full aborts with code 10. A conflict in the same cycle takes priority and gives code 01.
- R8: The effect of `tx_end` in ACTIVE depends on the write table:
  - With stores buffered, `busy` rises and one line per cycle is presented on `mem_wr_*`, in first-store order. A line stored several times carries its latest data. `commit_done` pulses in the cycle after the last line.
  - With no stores buffered, `commit_done` pulses in the next cycle and no memory write is made.
  - A conflict in the same cycle as `tx_end` wins, and no commit takes place.
- R9: After an abort, `tx_active` is low, both tables are empty and the buffered data is gone. `abort_code` holds its value until the next `tx_begin`, which returns it to 00.
- R10: `snp_ready` is low while `busy` is high. Snoops offered during the drain, or in IDLE, are not evaluated and cause no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin | input | 1 | Start a transaction (taken in IDLE) |
| tx_end | input | 1 | Request commit (taken in ACTIVE) |
| acc_valid | input | 1 | Local access present |
| acc_kind | input | 2 | 00 load, 01 store, 10 lock-taking write |
| acc_addr | input | ADDR_W | Local access byte address |
| acc_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Remote access present |
| snp_is_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | ADDR_W | Remote access byte address |
| snp_ready | output | 1 | Snoop is evaluated this cycle |
| tx_active | output | 1 | Transaction running |
| busy | output | 1 | Commit drain in progress |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_code | output | 2 | 00 none, 01 conflict, 10 capacity |
| commit_done | output | 1 | One-cycle commit completion |
| mem_wr_valid | output | 1 | Drained line valid |
| mem_wr_line | output | ADDR_W-OFF_W | Drained line address |
| mem_wr_data | output | DATA_W | Drained line data |

## Verification
The bench builds the block with its defaults: a 12-bit address, 2 offset bits, 8-bit data, 8 read slots and 4 write slots. These small depths let the bench fill each table to the brim, varying the offsets within each line, and then step exactly one line past it. The full drain order can be checked line by line. The bench also sweeps every pairing of access kind (load, store, lock write), snoop direction and line match or miss. It then covers the same-cycle collisions of a conflict with a capacity overflow and of a conflict with `tx_end`.

// File: rtl/txn_pkg.sv
package txn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } txn_state_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_LOCK  = 2'b10
    } acc_kind_e;

    localparam logic [1:0] ABORT_NONE     = 2'b00;
    localparam logic [1:0] ABORT_CONFLICT = 2'b01;
    localparam logic [1:0] ABORT_CAPACITY = 2'b10;
endpackage

// File: rtl/txn_line_table.sv
// Fully associative table of cache-line tags with an optional data slot
// per entry. Entries fill in arrival order; clear empties the table.
module txn_line_table #(
    parameter int DEPTH     = 8,
    parameter int TAG_W     = 10,
    parameter int DATA_W    = 8,
    parameter int KEEP_DATA = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [TAG_W-1:0]           wr_tag,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       lk_hit,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [TAG_W-1:0]           pr_tag,
    output logic                       pr_hit,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [TAG_W-1:0]           rd_tag,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] live, lk_v, pr_v;
    logic             append;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign live[i] = CNT_W'(i) < cnt_q;
        assign lk_v[i] = live[i] && (tag_q[i] == wr_tag);
        assign pr_v[i] = live[i] && (tag_q[i] == pr_tag);
    end

    assign lk_hit = |lk_v;
    assign pr_hit = |pr_v;
    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign count  = cnt_q;
    assign append = !clear && wr_en && !lk_hit && !full;
    assign rd_tag = tag_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (append) begin
            tag_q[cnt_q[IDX_W-1:0]] <= wr_tag;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    if (KEEP_DATA != 0) begin : g_data
        logic [DATA_W-1:0] data_q [DEPTH];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
            end else if (!clear && wr_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (lk_v[i] || (append && CNT_W'(i) == cnt_q))
                        data_q[i] <= wr_data;
                end
            end
        end
        assign rd_data = data_q[rd_idx];
    end else begin : g_nodata
        logic unused_data;
        assign unused_data = ^wr_data;
        assign rd_data = '0;
    end

    // R7: occupancy never exceeds the table depth
    p_tbl_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    // R1: a line is held at most once
    p_tbl_unique_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_v) <= 1);
    // R2: a new line with room takes exactly one slot
    p_tbl_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && wr_en && !lk_hit && !full) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/txn_fsm.sv
// Transaction control: begin, abort, commit and drain sequencing.
module txn_fsm
    import txn_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_begin,
    input  logic             tx_end,
    input  logic             conflict,
    input  logic             capacity,
    input  logic [CNT_W-1:0] wr_count,
    output txn_state_e       state,
    output logic [CNT_W-1:0] drain_idx,
    output logic             clear_sets,
    output logic             abort_pulse,
    output logic [1:0]       abort_code,
    output logic             commit_done
);
    txn_state_e       state_q, state_d;
    logic [CNT_W-1:0] drain_idx_q;
    logic             abort_pulse_q, commit_done_q;
    logic [1:0]       abort_code_q;
    logic             ev_conf, ev_cap, ev_quick, ev_done, drain_last;

    assign drain_last = (drain_idx_q + CNT_W'(1)) == wr_count;

    always_comb begin
        state_d  = state_q;
        ev_conf  = 1'b0;
        ev_cap   = 1'b0;
        ev_quick = 1'b0;
        ev_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_begin) state_d = ST_ACTIVE;            // BEGIN
            end
            ST_ACTIVE: begin
                if (conflict) begin                           // CONFLICT-ABORT
                    ev_conf = 1'b1;
                    state_d = ST_IDLE;
                end else if (tx_end) begin
                    if (wr_count == '0) begin                 // EMPTY-COMMIT
                        ev_quick = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin                            // COMMIT
                        state_d = ST_DRAIN;
                    end
                end else if (capacity) begin                  // CAPACITY-ABORT
                    ev_cap  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (drain_last) begin                         // DRAIN-DONE
                    ev_done = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drain_idx_q   <= '0;
            abort_pulse_q <= 1'b0;
            abort_code_q  <= ABORT_NONE;
            commit_done_q <= 1'b0;
        end else begin
            abort_pulse_q <= ev_conf || ev_cap;
            commit_done_q <= ev_quick || ev_done;
            if (state_q == ST_IDLE && tx_begin) abort_code_q <= ABORT_NONE;
            else if (ev_conf)                   abort_code_q <= ABORT_CONFLICT;
            else if (ev_cap)                    abort_code_q <= ABORT_CAPACITY;
            if (state_q == ST_ACTIVE)      drain_idx_q <= '0;
            else if (state_q == ST_DRAIN)  drain_idx_q <= drain_idx_q + CNT_W'(1);
        end
    end

    assign state       = state_q;
    assign drain_idx   = drain_idx_q;
    assign clear_sets  = ev_conf || ev_cap || ev_quick || ev_done;
    assign abort_pulse = abort_pulse_q;
    assign abort_code  = abort_code_q;
    assign commit_done = commit_done_q;

    // R8: drain presents one line per cycle
    p_drain_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && $past(state_q) == ST_DRAIN)
            |-> drain_idx_q == $past(drain_idx_q) + CNT_W'(1));
    // R9: an abort always leaves the transaction
    p_abort_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse_q |-> state_q == ST_IDLE);
    // R9: an abort always carries a reason
    p_abort_coded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse_q |-> abort_code_q != ABORT_NONE);
endmodule

// File: rtl/txn_footprint_tracker.sv
module txn_footprint_tracker
    import txn_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFF_W    = 2,
    parameter int DATA_W   = 8,
    parameter int RD_DEPTH = 8,
    parameter int WR_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_begin,
    input  logic                    tx_end,
    input  logic                    acc_valid,
    input  logic [1:0]              acc_kind,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [DATA_W-1:0]       acc_data,
    input  logic                    snp_valid,
    input  logic                    snp_is_write,
    input  logic [ADDR_W-1:0]       snp_addr,
    output logic                    snp_ready,
    output logic                    tx_active,
    output logic                    busy,
    output logic                    abort_pulse,
    output logic [1:0]              abort_code,
    output logic                    commit_done,
    output logic                    mem_wr_valid,
    output logic [ADDR_W-OFF_W-1:0] mem_wr_line,
    output logic [DATA_W-1:0]       mem_wr_data
);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int RCNT_W = $clog2(RD_DEPTH + 1);
    localparam int RIDX_W = $clog2(RD_DEPTH);
    localparam int WCNT_W = $clog2(WR_DEPTH + 1);
    localparam int WIDX_W = $clog2(WR_DEPTH);

    txn_state_e        state;
    logic [LINE_W-1:0] acc_line, snp_line;
    logic              in_tx, to_read, to_write, snp_take;
    logic              rd_hit, rd_full, rd_phit, wr_hit, wr_full, wr_phit;
    logic              rd_cap, wr_cap, conflict, capacity, clear_sets, quiet;
    logic              rd_ins, wr_ins;
    logic [RCNT_W-1:0] rd_count;
    logic [WCNT_W-1:0] wr_count, drain_idx;
    logic [LINE_W-1:0] rs_unused_tag;
    logic              rs_unused_data;
    logic              unused_bits;

    assign acc_line = acc_addr[ADDR_W-1:OFF_W];
    assign snp_line = snp_addr[ADDR_W-1:OFF_W];
    assign unused_bits = ^{acc_addr[OFF_W-1:0], snp_addr[OFF_W-1:0], rd_count,
                           rs_unused_tag, rs_unused_data, drain_idx};

    assign in_tx    = (state == ST_ACTIVE);
    assign to_read  = (acc_kind == ACC_LOAD) || (acc_kind == ACC_LOCK);
    assign to_write = (acc_kind == ACC_STORE);
    assign snp_take = in_tx && snp_valid;

    assign conflict = snp_take && (wr_phit || (snp_is_write && rd_phit));
    assign rd_cap   = in_tx && acc_valid && to_read  && !rd_hit && rd_full;
    assign wr_cap   = in_tx && acc_valid && to_write && !wr_hit && wr_full;
    assign capacity = rd_cap || wr_cap;
    assign quiet    = in_tx && !conflict && !tx_end && !capacity && acc_valid;
    assign rd_ins   = quiet && to_read;
    assign wr_ins   = quiet && to_write;

    txn_line_table #(
        .DEPTH(RD_DEPTH), .TAG_W(LINE_W), .DATA_W(1), .KEEP_DATA(0)
    ) u_read_set (
        .clk(clk), .rst_n(rst_n), .clear(clear_sets),
        .wr_en(rd_ins), .wr_tag(acc_line), .wr_data(1'b0),
        .lk_hit(rd_hit), .full(rd_full), .count(rd_count),
        .pr_tag(snp_line), .pr_hit(rd_phit),
        .rd_idx({RIDX_W{1'b0}}), .rd_tag(rs_unused_tag), .rd_data(rs_unused_data)
    );

    txn_line_table #(
        .DEPTH(WR_DEPTH), .TAG_W(LINE_W), .DATA_W(DATA_W), .KEEP_DATA(1)
    ) u_write_set (
        .clk(clk), .rst_n(rst_n), .clear(clear_sets),
        .wr_en(wr_ins), .wr_tag(acc_line), .wr_data(acc_data),
        .lk_hit(wr_hit), .full(wr_full), .count(wr_count),
        .pr_tag(snp_line), .pr_hit(wr_phit),
        .rd_idx(drain_idx[WIDX_W-1:0]), .rd_tag(mem_wr_line), .rd_data(mem_wr_data)
    );

    txn_fsm #(.CNT_W(WCNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
        .conflict(conflict), .capacity(capacity), .wr_count(wr_count),
        .state(state), .drain_idx(drain_idx), .clear_sets(clear_sets),
        .abort_pulse(abort_pulse), .abort_code(abort_code), .commit_done(commit_done)
    );

    assign tx_active    = in_tx;
    assign busy         = (state == ST_DRAIN);
    assign snp_ready    = !busy;
    assign mem_wr_valid = busy;

    // R4/R5: a conflicting snoop aborts with code 01 on the next cycle
    p_conflict_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> abort_pulse && abort_code == ABORT_CONFLICT);
    // R7: overflow without conflict or commit aborts with code 10
    p_cap_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capacity && !conflict && !tx_end) |=> abort_pulse && abort_code == ABORT_CAPACITY);
    // R3: nothing is written to memory while speculative
    p_no_spec_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !mem_wr_valid);
    // R10: snoops are stalled only while draining
    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_ready |-> !tx_active && !abort_pulse);
endmodule

// File: tb/txn_footprint_tracker_test.sv
module txn_footprint_tracker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_begin = 0, tx_end = 0, acc_valid = 0, snp_valid = 0, snp_is_write = 0;
    logic [1:0]  acc_kind = 0;
    logic [11:0] acc_addr = 0, snp_addr = 0;
    logic [7:0]  acc_data = 0;
    logic        snp_ready, tx_active, busy, abort_pulse, commit_done, mem_wr_valid;
    logic [1:0]  abort_code;
    logic [9:0]  mem_wr_line;
    logic [7:0]  mem_wr_data;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_footprint_tracker uut (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_end(tx_end),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_data(acc_data),
        .snp_valid(snp_valid), .snp_is_write(snp_is_write), .snp_addr(snp_addr),
        .snp_ready(snp_ready), .tx_active(tx_active), .busy(busy),
        .abort_pulse(abort_pulse), .abort_code(abort_code), .commit_done(commit_done),
        .mem_wr_valid(mem_wr_valid), .mem_wr_line(mem_wr_line), .mem_wr_data(mem_wr_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] addr_of(input int line, input int off);
        return 12'((line << 2) | (off & 3));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
        tx_begin = 0; tx_end = 0; acc_valid = 0; snp_valid = 0; snp_is_write = 0;
    endtask

    task automatic access(input int kind, input int line, input int off, input int data);
        acc_valid = 1; acc_kind = 2'(kind); acc_addr = addr_of(line, off); acc_data = 8'(data);
        tick();
    endtask

    task automatic snoop(input int wr, input int line, input int off);
        snp_valid = 1; snp_is_write = 1'(wr); snp_addr = addr_of(line, off);
        tick();
    endtask

    task automatic start_tx();
        tx_begin = 1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // reset state
        check("R10 reset snp_ready", int'(snp_ready), 1);
        check("R9 reset tx_active", int'(tx_active), 0);
        check("R8 reset busy", int'(busy), 0);
        check("R9 reset abort_code", int'(abort_code), 0);

        // R2: idle accesses and snoops are ignored
        access(1, 5, 0, 8'h77);
        snoop(1, 5, 0);
        check("R2 idle snoop no abort", int'(abort_pulse), 0);
        start_tx();
        check("R2 begin active", int'(tx_active), 1);
        tx_end = 1; tick();
        check("R2 idle store not buffered", int'(mem_wr_valid), 0);
        check("R8 empty commit done", int'(commit_done), 1);

        // R1/R7: read table sweep with varied offsets
        start_tx();
        for (int i = 0; i < 8; i++) begin
            access(0, i + 1, i % 4, 0);
            access(0, i + 1, (i + 1) % 4, 0);
        end
        check("R1 same-line loads fit", int'(tx_active), 1);
        snoop(0, 1, 2);
        check("R5 remote read on read-set no abort", int'(abort_pulse), 0);
        access(0, 9, 0, 0);
        check("R7 read overflow abort", int'(abort_pulse), 1);
        check("R7 read overflow code", int'(abort_code), 2);
        check("R9 inactive after abort", int'(tx_active), 0);
        tick();
        check("R9 pulse single", int'(abort_pulse), 0);
        check("R9 code held", int'(abort_code), 2);
        start_tx();
        check("R9 code cleared at begin", int'(abort_code), 0);
        snoop(1, 1, 0);
        check("R9 read table cleared", int'(abort_pulse), 0);
        tx_end = 1; tick();
        check("R9 commit after clear", int'(commit_done), 1);

        // R3/R6/R8/R10: write table fill, drain order
        start_tx();
        for (int i = 0; i < 4; i++) begin
            access(1, 16 + i, i, 8'hA0 + i);
            check("R3 no write while active", int'(mem_wr_valid), 0);
        end
        access(1, 17, 3, 8'h5C);
        access(2, 48, 0, 8'h11);
        check("R6 lock write uses no write slot", int'(tx_active), 1);
        tx_end = 1; tick();
        check("R10 snp_ready low when busy", int'(snp_ready), 0);
        for (int i = 0; i < 4; i++) begin
            check("R8 drain valid", int'(mem_wr_valid), 1);
            check("R8 drain line", int'(mem_wr_line), 16 + i);
            check("R8 drain data", int'(mem_wr_data), (i == 1) ? 8'h5C : 8'hA0 + i);
            check("R10 no abort in drain", int'(abort_pulse), 0);
            if (i == 1) begin snp_valid = 1; snp_is_write = 1; snp_addr = addr_of(16, 0); end
            tick();
        end
        check("R8 commit_done after drain", int'(commit_done), 1);
        check("R8 busy released", int'(busy), 0);
        check("R10 drain snoop ignored", int'(abort_pulse), 0);

        // R7/R9: write overflow then buffer dropped
        start_tx();
        for (int i = 0; i < 4; i++) access(1, 64 + i, 0, i);
        access(1, 68, 0, 9);
        check("R7 write overflow code", int'(abort_code), 2);
        start_tx();
        tx_end = 1; tick();
        check("R9 buffer dropped", int'(mem_wr_valid), 0);
        check("R9 empty commit", int'(commit_done), 1);

        // R4/R5/R6: sweep kind x snoop direction x line match
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 2; s++) begin
                    int exp_ab;
                    exp_ab = (s == 1 && (k == 1 || w == 1)) ? 1 : 0;
                    start_tx();
                    access(k, 32, 1, 8'h33);
                    snoop(w, (s == 1) ? 32 : 33, 3);
                    check("R4 R5 sweep abort", int'(abort_pulse), exp_ab);
                    if (exp_ab == 1) check("R4 sweep code", int'(abort_code), 1);
                    else begin
                        tx_end = 1; tick();
                        if (k == 1) begin
                            check("R8 sweep drain line", int'(mem_wr_line), 32);
                            check("R8 sweep drain data", int'(mem_wr_data), 8'h33);
                            tick();
                        end else begin
                            check("R6 lock/load not drained", int'(mem_wr_valid), 0);
                        end
                        check("R8 sweep commit", int'(commit_done), 1);
                    end
                end

        // R7: conflict wins over capacity in the same cycle
        start_tx();
        for (int i = 0; i < 4; i++) access(1, 80 + i, 0, i);
        acc_valid = 1; acc_kind = 2'b01; acc_addr = addr_of(84, 0);
        snp_valid = 1; snp_is_write = 1; snp_addr = addr_of(80, 1);
        tick();
        check("R7 conflict priority code", int'(abort_code), 1);

        // R8: conflict wins over tx_end
        start_tx();
        access(0, 96, 0, 0);
        tx_end = 1; snp_valid = 1; snp_is_write = 1; snp_addr = addr_of(96, 2);
        tick();
        check("R8 conflict beats commit", int'(abort_code), 1);
        check("R8 no commit_done", int'(commit_done), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule